// File: doc/BRIEF.md
# Partitioned Slot Allocator

This block tracks which entries of a small pool of fixed-size message slots are in use and hands free ones to two requesters: a receive path and a transmit path. A request is answered in the same cycle with the index of the lowest free slot the requester may use. That slot is marked used at the next clock edge, so it is never handed out twice. A release port returns a slot to the pool by index.

The lowest quarter of the pool is kept for the receive path. A transmit search starts at slot `POOL/4`, while a receive search starts at slot 0. A flood of outgoing messages can therefore never take the buffers needed to accept the replies. When both requesters ask in the same cycle, receive is served first and transmit picks from what is left.

A release and an allocation in the same cycle resolve release-first, so a slot freed in a cycle can be granted in that same cycle.

The block has no sequencing state. Its only state is the per-slot used flag, which is cleared by the active-low asynchronous reset. In every cycle the block makes one transition, with no named states: from the current flags, minus the slot released this cycle, plus the slots granted this cycle, to the flags for the next cycle.

Top module: `slot_pool_alloc`

## Requirements
- R1: Reset clears every used flag. After reset, a receive request is granted slot 0 and a simultaneous transmit request is granted slot `POOL/4`.
- R2: A receive request is granted the lowest-indexed free slot in the range 0 to `POOL-1`. The grant appears in the same cycle as the request.
- R3: A transmit request is granted only a slot with an index of at least `POOL/4`, and it gets the lowest free slot in that range.
- R4: A granted slot is marked used at the following clock edge and is not granted again until it is released.
- R5: When no slot in the allowed range is free, the request drives its fail output high and its grant output low, and reports index 0. A grant and a fail never occur together.
- R6: A transmit request fails when only slots below `POOL/4` are free, and those slots stay available to receive requests.
- R7: A release with a valid index clears that slot's used flag, so the slot can be granted again.
- R8: When receive and transmit requests arrive in the same cycle, receive is served first and transmit is served from the remaining slots. The two granted indices always differ.
- R9: A release and a request in the same cycle are resolved release-first. The released slot can be granted in that cycle, and it ends the cycle marked used.
- R10: Without a request, a path's grant and fail outputs stay low, and no used flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_req | input | 1 | Receive path asks for a slot |
| tx_req | input | 1 | Transmit path asks for a slot |
| rel_valid | input | 1 | Release the slot given by rel_idx |
| rel_idx | input | $clog2(POOL) | Index of the slot to release |
| rx_grant | output | 1 | Receive request served |
| rx_fail | output | 1 | Receive request found no free slot |
| rx_idx | output | $clog2(POOL) | Slot granted to receive (0 when not granted) |
| tx_grant | output | 1 | Transmit request served |
| tx_fail | output | 1 | Transmit request found no free slot in its range |
| tx_idx | output | $clog2(POOL) | Slot granted to transmit (0 when not granted) |

## Verification
The default 16-slot pool is tested with several directed sequences:

- **Receive-only fill.** Filling the whole pool with receive requests shows that a receive search starts at slot 0.
- **Transmit-only fill.** Filling with transmit requests shows that a transmit search starts at slot 4 and fails while slots 0 to 3 are still free.
- **Simultaneous requests on a full pool.** Both paths asking at once shows that receive has priority.
- **Same-slot release and request.** Releasing a slot while requesting on a full pool shows whether the release is applied before the search.

A long run of pseudo-random request and release patterns is then compared cycle by cycle against a bench model of the used flags. This run checks lowest-index choice and the handling of holes across mixed occupancy.

// File: rtl/slot_pool_pkg.sv
package slot_pool_pkg;

    // Requester class: selects where a free-slot search starts.
    typedef enum logic {
        REQ_RX = 1'b0,
        REQ_TX = 1'b1
    } req_class_e;

endpackage

// File: rtl/slot_used_bank.sv
module slot_used_bank #(
    parameter int POOL = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [POOL-1:0] clr_mask,
    input  logic [POOL-1:0] set_mask,
    output logic [POOL-1:0] used
);

    // One flag per slot. A set wins over a clear, so a slot released and
    // re-granted in the same cycle ends the cycle used.
    for (genvar s = 0; s < POOL; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                used[s] <= 1'b0;
            end else if (set_mask[s]) begin
                used[s] <= 1'b1;
            end else if (clr_mask[s]) begin
                used[s] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/slot_free_search.sv
module slot_free_search
    import slot_pool_pkg::*;
#(
    parameter int         POOL = 16,
    parameter req_class_e CLS  = REQ_RX,
    localparam int        IW   = $clog2(POOL)
) (
    input  logic            req,
    input  logic [POOL-1:0] avail,
    output logic            grant,
    output logic            fail,
    output logic [IW-1:0]   idx,
    output logic [POOL-1:0] onehot
);

    // The requester class decides the lowest index this search may return.
    localparam int LO = (CLS == REQ_TX) ? POOL / 4 : 0;

    logic          hit;
    logic [IW-1:0] sel;

    always_comb begin
        hit = 1'b0;
        sel = '0;
        // Walk downward so the last hit kept is the lowest index.
        for (int i = POOL - 1; i >= LO; i--) begin
            if (avail[i]) begin
                hit = 1'b1;
                sel = IW'(i);
            end
        end
    end

    always_comb begin
        grant  = req & hit;
        fail   = req & ~hit;
        idx    = grant ? sel : '0;
        onehot = grant ? (POOL'(1) << sel) : '0;
    end

endmodule

// File: rtl/slot_pool_alloc.sv
module slot_pool_alloc
    import slot_pool_pkg::*;
#(
    parameter int  POOL = 16,
    localparam int IW   = $clog2(POOL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_req,
    input  logic          tx_req,
    input  logic          rel_valid,
    input  logic [IW-1:0] rel_idx,
    output logic          rx_grant,
    output logic          rx_fail,
    output logic [IW-1:0] rx_idx,
    output logic          tx_grant,
    output logic          tx_fail,
    output logic [IW-1:0] tx_idx
);

    logic [POOL-1:0] used_q;
    logic [POOL-1:0] rel_mask;
    logic [POOL-1:0] free_now;
    logic [POOL-1:0] tx_avail;
    logic [POOL-1:0] rx_oh;
    logic [POOL-1:0] tx_oh;

    // The release is applied first, so the freed slot joins this cycle's search.
    always_comb begin
        rel_mask = rel_valid ? (POOL'(1) << rel_idx) : '0;
        free_now = ~used_q | rel_mask;
        tx_avail = free_now & ~rx_oh;   // receive has priority
    end

    slot_free_search #(.POOL(POOL), .CLS(REQ_RX)) u_rx_search (
        .req    (rx_req),
        .avail  (free_now),
        .grant  (rx_grant),
        .fail   (rx_fail),
        .idx    (rx_idx),
        .onehot (rx_oh)
    );

    slot_free_search #(.POOL(POOL), .CLS(REQ_TX)) u_tx_search (
        .req    (tx_req),
        .avail  (tx_avail),
        .grant  (tx_grant),
        .fail   (tx_fail),
        .idx    (tx_idx),
        .onehot (tx_oh)
    );

    slot_used_bank #(.POOL(POOL)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mask (rel_mask),
        .set_mask (rx_oh | tx_oh),
        .used     (used_q)
    );

endmodule

// File: rtl/slot_pool_alloc_chk.sv
module slot_pool_alloc_chk #(
    parameter int  POOL = 16,
    localparam int IW   = $clog2(POOL)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_req,
    input logic            tx_req,
    input logic            rel_valid,
    input logic [IW-1:0]   rel_idx,
    input logic            rx_grant,
    input logic            rx_fail,
    input logic [IW-1:0]   rx_idx,
    input logic            tx_grant,
    input logic            tx_fail,
    input logic [IW-1:0]   tx_idx,
    input logic [POOL-1:0] used_q
);

    localparam int Q = POOL / 4;

    // R1: the flags are clear while reset is held
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (used_q == '0));

    // R3: a transmit grant never lands in the reserved quarter
    p_tx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> (int'(tx_idx) >= Q));

    // R4: a receive grant leaves the slot used
    p_rx_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_grant |=> used_q[$past(rx_idx)]);

    // R4: a transmit grant leaves the slot used
    p_tx_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |=> used_q[$past(tx_idx)]);

    // R5: grant and fail exclude each other
    p_rx_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_grant && rx_fail));

    // R5: a receive fail means every slot was busy and none was released
    p_rx_fail_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fail |-> ((&used_q) && !rel_valid));

    // R7: a released slot that nobody takes ends up free
    p_rel_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !(rx_grant && rx_idx == rel_idx)
                   && !(tx_grant && tx_idx == rel_idx))
        |=> !used_q[$past(rel_idx)]);

    // R8: simultaneous grants never share a slot
    p_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_grant && tx_grant) |-> (rx_idx != tx_idx));

    // R10: no answer without a request
    p_rx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_req |-> !(rx_grant || rx_fail));

    p_tx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |-> !(tx_grant || tx_fail));

endmodule

bind slot_pool_alloc slot_pool_alloc_chk #(.POOL(POOL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_req    (rx_req),
    .tx_req    (tx_req),
    .rel_valid (rel_valid),
    .rel_idx   (rel_idx),
    .rx_grant  (rx_grant),
    .rx_fail   (rx_fail),
    .rx_idx    (rx_idx),
    .tx_grant  (tx_grant),
    .tx_fail   (tx_fail),
    .tx_idx    (tx_idx),
    .used_q    (used_q)
);

// File: tb/slot_pool_alloc_tb.sv
module slot_pool_alloc_tb;

    localparam int P  = 16;
    localparam int IW = $clog2(P);
    localparam int Q  = P / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_req = 1'b0, tx_req = 1'b0, rel_valid = 1'b0;
    logic [IW-1:0] rel_idx = '0;
    logic          rx_grant, rx_fail, tx_grant, tx_fail;
    logic [IW-1:0] rx_idx, tx_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit [P-1:0] mdl = '0;   // bench model of the used flags

    always #10 clk = ~clk;   // 50 MHz

    slot_pool_alloc #(.POOL(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
        .rel_valid(rel_valid), .rel_idx(rel_idx),
        .rx_grant(rx_grant), .rx_fail(rx_fail), .rx_idx(rx_idx),
        .tx_grant(tx_grant), .tx_fail(tx_fail), .tx_idx(tx_idx)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare the combinational answer,
    // then advance the model to match the next rising edge.
    task automatic step(input bit rq, input bit tq, input bit rv, input int ri,
                        input string tag);
        bit [P-1:0] eff;
        bit eg, ef, tg, tf;
        int ei, ti;
        @(negedge clk);
        rx_req = rq; tx_req = tq; rel_valid = rv; rel_idx = IW'(ri);
        #2;
        eff = ~mdl;
        if (rv) eff[ri] = 1'b1;
        eg = 1'b0; ei = 0;
        for (int i = 0; i < P; i++)
            if (rq && !eg && eff[i]) begin eg = 1'b1; ei = i; end
        ef = rq && !eg;
        if (eg) eff[ei] = 1'b0;
        tg = 1'b0; ti = 0;
        for (int i = Q; i < P; i++)
            if (tq && !tg && eff[i]) begin tg = 1'b1; ti = i; end
        tf = tq && !tg;
        if (tg) eff[ti] = 1'b0;
        chk(tag, "rx_grant", int'(rx_grant), int'(eg));
        chk(tag, "rx_fail",  int'(rx_fail),  int'(ef));
        chk(tag, "rx_idx",   int'(rx_idx),   ei);
        chk(tag, "tx_grant", int'(tx_grant), int'(tg));
        chk(tag, "tx_fail",  int'(tx_fail),  int'(tf));
        chk(tag, "tx_idx",   int'(tx_idx),   ti);
        mdl = ~eff;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_req = 0; tx_req = 0; rel_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl = '0;
    endtask

    task automatic release_all(input string tag);
        for (int s = 0; s < P; s++) step(0, 0, 1, s, tag);
    endtask

    initial begin
        do_reset();
        // R10: idle cycle answers nothing
        step(0, 0, 0, 0, "R10");
        // R1: fresh pool, both ask together -> rx 0, tx Q
        @(negedge clk); rx_req = 1; tx_req = 1; #2;
        chk("R1", "rx_idx after reset", int'(rx_idx), 0);
        chk("R1", "tx_idx after reset", int'(tx_idx), Q);
        rx_req = 0; tx_req = 0;
        do_reset();

        // R2/R4: receive-only fill walks 0..P-1
        for (int k = 0; k < P; k++) begin
            step(1, 0, 0, 0, "R2");
            chk("R4", "fill order", int'(rx_idx), k);
        end
        // R5: pool full, both fail
        step(1, 1, 0, 0, "R5");
        chk("R5", "rx_fail full", int'(rx_fail), 1);
        // R9: full pool, release slot 7 while requesting -> 7 re-granted
        step(1, 0, 1, 7, "R9");
        chk("R9", "regrant", int'(rx_idx), 7);
        step(1, 0, 0, 0, "R9");   // still full afterwards
        chk("R9", "slot stays used", int'(rx_fail), 1);
        // R8: full pool, free 3 and 9, both ask: rx takes 3, tx takes 9
        step(0, 0, 1, 3, "R7");
        step(0, 0, 1, 9, "R7");
        step(1, 1, 0, 0, "R8");
        chk("R8", "rx first", int'(rx_idx), 3);
        chk("R8", "tx rest", int'(tx_idx), 9);
        // R8: only slot 10 free, both ask -> rx wins, tx fails
        step(0, 0, 1, 10, "R7");
        step(1, 1, 0, 0, "R8");
        chk("R8", "tx fails after rx wins", int'(tx_fail), 1);
        release_all("R7");

        // R3/R6: transmit-only fill walks Q..P-1 then fails with 0..Q-1 free
        for (int k = Q; k < P; k++) begin
            step(0, 1, 0, 0, "R3");
            chk("R3", "tx order", int'(tx_idx), k);
        end
        step(0, 1, 0, 0, "R6");
        chk("R6", "tx blocked by reserve", int'(tx_fail), 1);
        step(1, 0, 0, 0, "R6");
        chk("R6", "rx uses reserve", int'(rx_idx), 0);
        // R7: release 12 then tx gets 12
        step(0, 0, 1, 12, "R7");
        step(0, 1, 0, 0, "R7");
        chk("R7", "released slot reused", int'(tx_idx), 12);

        // R1: reset mid-run clears everything
        do_reset();
        step(1, 1, 0, 0, "R1");

        // Mixed pseudo-random sweep against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 15));
            step(r[0], r[1], r[2] | r[3], int'($urandom_range(0, P - 1)), "R2");
        end

        @(negedge clk);
        rx_req = 0; tx_req = 0; rel_valid = 0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule